// File: doc/BRIEF.md
# LED Blink Pattern Controller

This block drives a small group of active-low indicator LEDs. Each LED is set up on its own through a single write port. The write names the LED and carries its mode (dark, steady or flashing), its lit and unlit durations, a flash count and a long-gap duration. While an LED flashes, every Nth unlit gap is replaced once by the long gap, and then the flash sequence starts over. Every duration counts pulses of an external `tick` input, which is meant to pulse once every 1/16 s.

A power-fail input blanks every LED at once. It also drops the `busy` flag, which otherwise tells a power manager that sleep must be held off. The stored settings survive the blanking. When power-fail clears, every LED takes up its stored mode again, and a flashing LED restarts at the beginning of a lit interval. A status output gives the stored mode code of each LED.

Each LED runs a channel state machine with five states:
- `ST_IDLE`: dark, for mode 0 and for the reserved code 3.
- `ST_STEADY`: lit.
- `ST_LIT`: the lit part of a flash.
- `ST_GAP`: a normal unlit gap.
- `ST_LONG_GAP`: the long unlit gap.

The channel moves between states as follows:
- Load: a configuration write moves the channel to its entry state. The entry state is `ST_STEADY` for mode 1, `ST_LIT` for mode 2 and `ST_IDLE` otherwise.
- Hold: while power-fail is high, the channel is held in the entry state of its stored mode.
- Lit to gap: when the lit timer expires on a tick, `ST_LIT` goes to `ST_GAP`. If that flash completes a group of N, it goes to `ST_LONG_GAP` instead.
- Gap to lit: when the gap timer expires, `ST_GAP` and `ST_LONG_GAP` return to `ST_LIT`.

Top module: `led_blink_ctrl`

## Requirements
- R1: After reset every `led_n` bit is 1, every status field reads 0 and `busy` is 0.
- R2: Mode code 0 keeps the LED dark (`led_n` = 1). Code 1 keeps it lit (`led_n` = 0). Code 2 flashes it. The status bits [2i+1:2i] hold the code last written to LED i.
- R3: Mode code 3 is accepted and stored. The LED stays dark, its status field reads 3 and it does not count towards `busy`.
- R4: In mode 2 the LED is lit from the write on, for `on_t` ticks. It is then dark for `off_t` ticks, and the pattern repeats.
- R5: When `cnt` is non-zero, every `cnt`-th dark gap lasts `meta_t` ticks instead of `off_t`, and the flash count starts over. When `cnt` is 0, no long gap is ever inserted.
- R6: A duration of 0 (`on_t`, `off_t` or `meta_t`) behaves as one tick.
- R7: A write restarts only the selected LED, and the other LEDs keep their pattern. A write whose `cfg_sel` is not below NUM_LEDS changes nothing. Status changes only on a write.
- R8: While `pwr_fail` is 1, every `led_n` bit is 1 in the same cycle, ticks have no effect and status is kept. After release, each LED follows its stored mode, and a flashing LED starts again at a lit interval.
- R9: `busy` is 1 exactly when `pwr_fail` is 0 and at least one LED holds code 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse per 1/16 s time unit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SELW | LED number for the write |
| cfg_mode | input | 2 | Mode code: 0 off, 1 on, 2 flash, 3 none |
| cfg_on_t | input | TW | Lit duration in ticks |
| cfg_off_t | input | TW | Normal dark duration in ticks |
| cfg_cnt | input | CW | Flashes per group before the long gap; 0 disables the long gap |
| cfg_meta_t | input | TW | Long dark duration in ticks |
| pwr_fail | input | 1 | Power-fail blanking, active high |
| led_n | output | NUM_LEDS | LED drives, active low |
| led_status | output | 2*NUM_LEDS | Stored mode code per LED |
| busy | output | 1 | Some LED is lit or flashing and power is good |

## Verification
The hardest situation to reach is a long gap that lands in the middle of a pattern that has just been restarted. This happens when a power-fail release or a write on another LED falls between flashes. Getting there needs several LEDs flashing at once with short, mismatched durations, interleaved with power-fail pulses.

The stimulus runs hundreds of randomly chosen steps over small duration and count values, so the long-gap boundaries keep colliding with restarts. A bench function replays each LED's pattern from the number of ticks since its last restart.

// File: rtl/led_pkg.sv
package led_pkg;

    typedef enum logic [1:0] {
        MODE_DARK   = 2'd0,
        MODE_STEADY = 2'd1,
        MODE_FLASH  = 2'd2,
        MODE_NONE   = 2'd3
    } led_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEADY,
        ST_LIT,
        ST_GAP,
        ST_LONG_GAP
    } chan_state_e;

    function automatic chan_state_e entry_state(input led_mode_e m);
        unique case (m)
            MODE_STEADY: entry_state = ST_STEADY;
            MODE_FLASH:  entry_state = ST_LIT;
            default:     entry_state = ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/led_wr_decode.sv
module led_wr_decode #(
    parameter int NUM_LEDS = 3,
    parameter int SELW     = 2
) (
    input  logic                we,
    input  logic [SELW-1:0]     sel,
    output logic [NUM_LEDS-1:0] load
);
    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_dec
        assign load[i] = we && (sel == SELW'(i));
    end
endmodule

// File: rtl/led_chan.sv
module led_chan
    import led_pkg::*;
#(
    parameter int TW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          hold,
    input  logic          load,
    input  led_mode_e     in_mode,
    input  logic [TW-1:0] in_on,
    input  logic [TW-1:0] in_off,
    input  logic [CW-1:0] in_cnt,
    input  logic [TW-1:0] in_meta,
    output led_mode_e     mode,
    output logic          lit
);
    led_mode_e     mode_q;
    logic [TW-1:0] on_q, off_q, meta_q;
    logic [CW-1:0] cnt_q;
    chan_state_e   state_q, state_d;
    logic [TW-1:0] timer_q, timer_d;
    logic [CW-1:0] flashes_q, flashes_d;

    function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] v);
        return (v == '0) ? TW'(1) : v;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_DARK;
            on_q   <= '0;
            off_q  <= '0;
            cnt_q  <= '0;
            meta_q <= '0;
        end else if (load) begin
            mode_q <= in_mode;
            on_q   <= in_on;
            off_q  <= in_off;
            cnt_q  <= in_cnt;
            meta_q <= in_meta;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            timer_q   <= '0;
            flashes_q <= '0;
        end else begin
            state_q   <= state_d;
            timer_q   <= timer_d;
            flashes_q <= flashes_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        timer_d   = timer_q;
        flashes_d = flashes_q;
        if (load) begin
            state_d   = entry_state(in_mode);
            timer_d   = at_least_one(in_on);
            flashes_d = '0;
        end else if (hold) begin
            state_d   = entry_state(mode_q);
            timer_d   = at_least_one(on_q);
            flashes_d = '0;
        end else if (tick) begin
            unique case (state_q)
                ST_LIT: begin
                    if (timer_q <= TW'(1)) begin
                        if (cnt_q != '0 && flashes_q + CW'(1) == cnt_q) begin
                            state_d   = ST_LONG_GAP;
                            timer_d   = at_least_one(meta_q);
                            flashes_d = '0;
                        end else begin
                            state_d   = ST_GAP;
                            timer_d   = at_least_one(off_q);
                            if (cnt_q != '0) flashes_d = flashes_q + CW'(1);
                        end
                    end else begin
                        timer_d = timer_q - TW'(1);
                    end
                end
                ST_GAP, ST_LONG_GAP: begin
                    if (timer_q <= TW'(1)) begin
                        state_d = ST_LIT;
                        timer_d = at_least_one(on_q);
                    end else begin
                        timer_d = timer_q - TW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mode = mode_q;
        lit  = !hold && (state_q == ST_STEADY || state_q == ST_LIT);
    end
endmodule

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl
    import led_pkg::*;
#(
    parameter int NUM_LEDS = 3,
    parameter int TW       = 8,
    parameter int CW       = 8,
    localparam int SELW    = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  cfg_we,
    input  logic [SELW-1:0]       cfg_sel,
    input  logic [1:0]            cfg_mode,
    input  logic [TW-1:0]         cfg_on_t,
    input  logic [TW-1:0]         cfg_off_t,
    input  logic [CW-1:0]         cfg_cnt,
    input  logic [TW-1:0]         cfg_meta_t,
    input  logic                  pwr_fail,
    output logic [NUM_LEDS-1:0]   led_n,
    output logic [2*NUM_LEDS-1:0] led_status,
    output logic                  busy
);
    logic [NUM_LEDS-1:0] load;
    logic [NUM_LEDS-1:0] lit;
    led_mode_e           modes [NUM_LEDS];

    led_wr_decode #(.NUM_LEDS(NUM_LEDS), .SELW(SELW)) u_dec (
        .we   (cfg_we),
        .sel  (cfg_sel),
        .load (load)
    );

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_chan
        led_chan #(.TW(TW), .CW(CW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .hold    (pwr_fail),
            .load    (load[i]),
            .in_mode (led_mode_e'(cfg_mode)),
            .in_on   (cfg_on_t),
            .in_off  (cfg_off_t),
            .in_cnt  (cfg_cnt),
            .in_meta (cfg_meta_t),
            .mode    (modes[i]),
            .lit     (lit[i])
        );
        assign led_n[i]            = ~lit[i];
        assign led_status[2*i +: 2] = modes[i];
    end

    always_comb begin
        busy = 1'b0;
        for (int i = 0; i < NUM_LEDS; i++)
            if (modes[i] == MODE_STEADY || modes[i] == MODE_FLASH) busy = 1'b1;
        busy = busy && !pwr_fail;
    end
endmodule

// File: rtl/led_blink_ctrl_chk.sv
module led_blink_ctrl_chk #(
    parameter int NUM_LEDS = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick,
    input logic                  cfg_we,
    input logic                  pwr_fail,
    input logic [NUM_LEDS-1:0]   led_n,
    input logic [2*NUM_LEDS-1:0] led_status,
    input logic                  busy
);
    logic any_active;
    always_comb begin
        any_active = 1'b0;
        for (int i = 0; i < NUM_LEDS; i++)
            if (led_status[2*i +: 2] == 2'd1 || led_status[2*i +: 2] == 2'd2) any_active = 1'b1;
    end

    AST_PF_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |-> (&led_n)); // R8
    AST_PF_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |-> !busy); // R9
    AST_BUSY_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> any_active); // R9
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(led_status)); // R7
    AST_QUIET_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cfg_we && !pwr_fail) |=> (pwr_fail || $stable(led_n))); // R4

    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
        AST_STEADY_LIT: assert property (@(posedge clk) disable iff (!rst_n)
            (led_status[2*i +: 2] == 2'd1 && !pwr_fail) |-> !led_n[i]); // R2
        AST_NOMODE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
            (led_status[2*i +: 2] == 2'd0 || led_status[2*i +: 2] == 2'd3) |-> led_n[i]); // R3
    end
endmodule

bind led_blink_ctrl led_blink_ctrl_chk #(.NUM_LEDS(NUM_LEDS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cfg_we     (cfg_we),
    .pwr_fail   (pwr_fail),
    .led_n      (led_n),
    .led_status (led_status),
    .busy       (busy)
);

// File: tb/tb_led_blink_ctrl.sv
module tb_led_blink_ctrl;
    localparam int N = 3;
    localparam int TW = 8;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, cfg_we = 1'b0, pwr_fail = 1'b0;
    logic [1:0] cfg_sel = '0, cfg_mode = '0;
    logic [TW-1:0] cfg_on_t = '0, cfg_off_t = '0, cfg_meta_t = '0;
    logic [CW-1:0] cfg_cnt = '0;
    logic [N-1:0] led_n;
    logic [2*N-1:0] led_status;
    logic busy;

    int checks = 0, failures = 0;
    int m_mode[N], m_on[N], m_off[N], m_cnt[N], m_meta[N], m_k[N];
    bit m_pf = 0;

    always #10 clk = ~clk;

    led_blink_ctrl #(.NUM_LEDS(N), .TW(TW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_mode(cfg_mode), .cfg_on_t(cfg_on_t), .cfg_off_t(cfg_off_t),
        .cfg_cnt(cfg_cnt), .cfg_meta_t(cfg_meta_t), .pwr_fail(pwr_fail),
        .led_n(led_n), .led_status(led_status), .busy(busy)
    );

    function automatic int one_min(int v);
        return (v == 0) ? 1 : v;
    endfunction

    // lit state of a flashing LED k ticks after its restart
    function automatic bit flash_lit(int a, int b, int c, int m, int k);
        int pos = 0;
        int fl = 0;
        int gap;
        a = one_min(a); b = one_min(b); m = one_min(m);
        for (int it = 0; it < 2000; it++) begin
            if (k < pos + a) return 1'b1;
            pos += a;
            fl++;
            if (c != 0 && fl == c) begin gap = m; fl = 0; end
            else gap = b;
            if (k < pos + gap) return 1'b0;
            pos += gap;
        end
        return 1'b0;
    endfunction

    function automatic bit exp_lit(int i);
        if (m_pf) return 1'b0;
        if (m_mode[i] == 1) return 1'b1;
        if (m_mode[i] == 2) return flash_lit(m_on[i], m_off[i], m_cnt[i], m_meta[i], m_k[i]);
        return 1'b0;
    endfunction

    function automatic bit exp_busy();
        if (m_pf) return 1'b0;
        for (int i = 0; i < N; i++) if (m_mode[i] == 1 || m_mode[i] == 2) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check_all(string tag);
        for (int i = 0; i < N; i++) begin
            checks++;
            if (led_n[i] !== ~exp_lit(i)) begin
                failures++;
                $display("FAIL %s led_n[%0d] actual=%b expected=%b", tag, i, led_n[i], ~exp_lit(i));
            end
            checks++;
            if (led_status[2*i +: 2] !== 2'(m_mode[i])) begin
                failures++;
                $display("FAIL R2 status[%0d] actual=%0d expected=%0d", i, led_status[2*i +: 2], m_mode[i]);
            end
        end
        checks++;
        if (busy !== exp_busy()) begin
            failures++;
            $display("FAIL R9 busy actual=%b expected=%b", busy, exp_busy());
        end
    endtask

    task automatic do_write(int sel, int md, int on, int off, int cnt, int meta);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_mode = 2'(md);
        cfg_on_t = TW'(on); cfg_off_t = TW'(off); cfg_cnt = CW'(cnt); cfg_meta_t = TW'(meta);
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel < N) begin
            m_mode[sel] = md; m_on[sel] = on; m_off[sel] = off;
            m_cnt[sel] = cnt; m_meta[sel] = meta; m_k[sel] = 0;
        end
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        if (!m_pf) for (int i = 0; i < N; i++) m_k[i]++;
    endtask

    task automatic set_pf(bit v);
        @(negedge clk); pwr_fail = v;
        @(negedge clk);
        m_pf = v;
        for (int i = 0; i < N; i++) m_k[i] = 0;
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int r;
        void'($urandom(32'd2024));
        for (int i = 0; i < N; i++) begin
            m_mode[i] = 0; m_on[i] = 0; m_off[i] = 0; m_cnt[i] = 0; m_meta[i] = 0; m_k[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        do_write(0, 1, 3, 3, 0, 0);
        check_all("R2");
        do_write(1, 3, 2, 2, 1, 1);
        check_all("R3");
        do_write(3, 1, 1, 1, 0, 0);   // out of range, ignored
        check_all("R7");

        do_write(2, 2, 2, 1, 2, 3);   // long gap after every 2nd flash
        for (int t = 0; t < 14; t++) begin do_tick(); check_all("R5"); end
        do_write(1, 2, 0, 0, 0, 0);   // zero durations
        for (int t = 0; t < 5; t++) begin do_tick(); check_all("R6"); end
        check_all("R7");

        set_pf(1'b1);
        check_all("R8");
        for (int t = 0; t < 3; t++) begin do_tick(); check_all("R8"); end
        set_pf(1'b0);
        check_all("R8");
        for (int t = 0; t < 4; t++) begin do_tick(); check_all("R4"); end

        for (int i = 0; i < N; i++) do_write(i, 0, 0, 0, 0, 0);
        check_all("R9");

        for (int s = 0; s < 600; s++) begin
            r = $urandom % 16;
            if (r < 2)
                do_write($urandom % N, $urandom % 4, $urandom % 4, $urandom % 4,
                         $urandom % 4, $urandom % 5);
            else if (r == 2)
                set_pf(!m_pf);
            else
                do_tick();
            check_all("R4");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule